// File: doc/BRIEF.md
# Dual-drive ATA PIO timing sequencer

This block drives the read and write strobes of one ATA channel that carries a master and a slave drive. Every strobe cycle has three phases, each counted in bus clocks: an address setup phase with both strobes idle, an active phase with one strobe asserted, and a recovery phase with the strobes idle again. A busy flag covers the whole cycle. Software chooses the length of each phase through a small write-only register port. Each drive can have its own pulse and recovery lengths, held in one of two timing sets. The address setup length is a single value that both drives share.

The register port stays locked until the host writes a key to the key offset, and a second key locks it again. With the port open, the host writes a small value to the miscellaneous offset to pick which timing set takes the next read-timing and write-timing writes. It opens access to the second set and turns on the per-drive mapping through the control offset. Any other value written to the miscellaneous offset sets the shared address setup. A cycle request names the drive and the direction. The block takes its timing values when the cycle starts and holds them to the end of that cycle.

Top module: `ata_pio_timing_seq`

## Requirements
- R1: After reset, busy is low and both strobes are inactive. Both sets hold 0xFF in their read and write timing, and address setup is 4 clocks, so the first cycle has 4 setup, 16 active and 17 recovery clocks. The port is locked, the set pointer is 0, and access to the second set and per-drive mapping are both off.
- R2: A write to any offset other than the key offset (2) changes nothing while the port is locked. Writing 0x03 to offset 2 opens the port and writing 0x83 to offset 2 closes it. Other values written to offset 2 have no effect.
- R3: A timing byte gives an active length of bits 7:4 plus 1 (1 to 16 clocks) and a recovery length of bits 3:0 plus 2 (2 to 17 clocks).
- R4: Offset 0 holds the read timing and offset 1 holds the write timing of the selected set. A read cycle uses only the read byte and a write cycle uses only the write byte.
- R5: A write of 0 or 1 to offset 6 sets the set pointer for later writes to offsets 0 and 1. A timing write aimed at set 1 is dropped unless access to set 1 has been opened by writing 0xC0 to offset 3.
- R6: Writing 0x85 to offset 3 maps drive 0 to set 0 and drive 1 to set 1. Writing 0xC0 to offset 3 leaves the mapping as it is. Any other value written to offset 3 clears both the mapping and the access to set 1. Without the mapping, both drives use set 0.
- R7: A write to offset 6 of any value other than 0 or 1 sets the shared address setup to bits 5:4 plus 1 (1 to 4 clocks). A write of 0 or 1 leaves the setup length unchanged.
- R8: When a request is accepted, busy is high from the next clock. The cycle then runs the setup clocks with both strobes inactive, then the active clocks with only the strobe of the requested direction asserted, then the recovery clocks with both strobes inactive. Busy falls after the last recovery clock. The strobes are active low.
- R9: A request that is present while busy is high is ignored. The running cycle keeps its direction, drive and length, and busy stays low for at least one clock after the cycle ends.
- R10: A cycle keeps the timing values it started with, even when register writes land while it is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all phase lengths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe, one clock per write |
| host_addr | input | ADDR_W (3) | Register offset |
| host_wdata | input | 8 | Register write data |
| cyc_req | input | 1 | Request a strobe cycle; taken only while idle |
| cyc_write | input | 1 | Direction of the requested cycle: 1 write, 0 read |
| cyc_drive | input | DRV_W (1) | Drive addressed by the requested cycle |
| dior_o | output | 1 | Read strobe, active low by default |
| diow_o | output | 1 | Write strobe, active low by default |
| busy_o | output | 1 | High from the first setup clock to the last recovery clock |

## Verification
The bench builds the block with its default parameters: two timing sets, a five-bit phase counter, active-low strobes and the default offsets and key values. These defaults reach the full encoding range. That covers the slowest reset cycle of 4+16+17 clocks, the shortest cycle of 1 active and 2 recovery clocks, and setup values of 2 and 4. A behavioural model counts elapsed clocks inside each cycle and is compared with busy and both strobes on every clock. Directed sequences cover the lock window, the dropped writes to set 1, the change of drive mapping, requests held high through a running cycle, and register writes that land in the middle of a cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } pio_phase_e;

   typedef struct packed {
      logic [3:0] pulse_m1;
      logic [3:0] recov_m2;
   } cyc_timing_t;

   localparam cyc_timing_t TIMING_SLOWEST = '{pulse_m1: 4'hF, recov_m2: 4'hF};
   localparam logic [1:0]  SETUP_SLOWEST  = 2'b11;

endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
   import ata_pio_pkg::*;
#(
   parameter int            ADDR_W     = 3,
   parameter int            NUM_SETS   = 2,
   parameter int            OFS_RD_TIM = 0,
   parameter int            OFS_WR_TIM = 1,
   parameter int            OFS_KEY    = 2,
   parameter int            OFS_CTRL   = 3,
   parameter int            OFS_MISC   = 6,
   parameter logic [7:0]    KEY_OPEN   = 8'h03,
   parameter logic [7:0]    KEY_CLOSE  = 8'h83,
   parameter logic [7:0]    CTRL_SPLIT = 8'h85,
   parameter logic [7:0]    CTRL_SET_B = 8'hC0,
   localparam int           SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_we,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [7:0]                 host_wdata,
   output cyc_timing_t [NUM_SETS-1:0] rd_sets_o,
   output cyc_timing_t [NUM_SETS-1:0] wr_sets_o,
   output logic [1:0]                 setup_m1_o,
   output logic                       split_o,
   output logic                       win_open_o
);

   localparam logic [ADDR_W-1:0] A_RD   = ADDR_W'(OFS_RD_TIM);
   localparam logic [ADDR_W-1:0] A_WR   = ADDR_W'(OFS_WR_TIM);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(OFS_MISC);
   localparam logic [7:0]        SETS_B = 8'(NUM_SETS);

   logic             win_q;
   logic             setb_q;
   logic             split_q;
   logic [SET_W-1:0] ptr_q;
   logic [1:0]       setup_q;

   logic key_hit;
   logic cfg_we;
   logic misc_we;
   logic ctrl_we;
   logic ptr_sel;

   assign key_hit = host_we && (host_addr == A_KEY);
   assign cfg_we  = host_we && win_q && (host_addr != A_KEY);
   assign misc_we = cfg_we && (host_addr == A_MISC);
   assign ctrl_we = cfg_we && (host_addr == A_CTRL);
   assign ptr_sel = (host_wdata < SETS_B);

   // key window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
      end else if (key_hit) begin
         if (host_wdata == KEY_OPEN) begin
            win_q <= 1'b1;
         end else if (host_wdata == KEY_CLOSE) begin
            win_q <= 1'b0;
         end
      end
   end

   // miscellaneous offset: set pointer or shared setup
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         setup_q <= SETUP_SLOWEST;
      end else if (misc_we) begin
         if (ptr_sel) begin
            ptr_q <= host_wdata[SET_W-1:0];
         end else begin
            setup_q <= host_wdata[5:4];
         end
      end
   end

   // control offset: set access and drive mapping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setb_q  <= 1'b0;
         split_q <= 1'b0;
      end else if (ctrl_we) begin
         if (host_wdata == CTRL_SET_B) begin
            setb_q <= 1'b1;
         end else if (host_wdata == CTRL_SPLIT) begin
            split_q <= 1'b1;
         end else begin
            setb_q  <= 1'b0;
            split_q <= 1'b0;
         end
      end
   end

   // one bank of read and write timing per set
   for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      logic        bank_ok;
      logic        rd_we;
      logic        wr_we;
      cyc_timing_t rd_q;
      cyc_timing_t wr_q;

      if (g == 0) begin : g_base
         assign bank_ok = (ptr_q == SET_W'(g));
      end else begin : g_gated
         assign bank_ok = (ptr_q == SET_W'(g)) && setb_q;
      end

      assign rd_we = cfg_we && bank_ok && (host_addr == A_RD);
      assign wr_we = cfg_we && bank_ok && (host_addr == A_WR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= TIMING_SLOWEST;
            wr_q <= TIMING_SLOWEST;
         end else begin
            if (rd_we) begin
               rd_q <= cyc_timing_t'(host_wdata);
            end
            if (wr_we) begin
               wr_q <= cyc_timing_t'(host_wdata);
            end
         end
      end

      assign rd_sets_o[g] = rd_q;
      assign wr_sets_o[g] = wr_q;
   end

   assign setup_m1_o = setup_q;
   assign split_o    = split_q;
   assign win_open_o = win_q;

endmodule

// File: rtl/ata_pio_sel.sv
module ata_pio_sel
   import ata_pio_pkg::*;
#(
   parameter int  NUM_SETS = 2,
   parameter int  CNT_W    = 5,
   localparam int DRV_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  cyc_timing_t [NUM_SETS-1:0] rd_sets_i,
   input  cyc_timing_t [NUM_SETS-1:0] wr_sets_i,
   input  logic [1:0]                 setup_m1_i,
   input  logic                       split_i,
   input  logic [DRV_W-1:0]           drive_i,
   input  logic                       is_write_i,
   output logic [CNT_W-1:0]           setup_clks_o,
   output logic [CNT_W-1:0]           pulse_clks_o,
   output logic [CNT_W-1:0]           recov_clks_o
);

   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

   logic [DRV_W-1:0] bank;
   cyc_timing_t      tsel;

   always_comb begin
      bank = split_i ? drive_i : '0;
      if (is_write_i) begin
         tsel = wr_sets_i[bank];
      end else begin
         tsel = rd_sets_i[bank];
      end
   end

   assign setup_clks_o = CNT_W'(setup_m1_i) + C_ONE;
   assign pulse_clks_o = CNT_W'(tsel.pulse_m1) + C_ONE;
   assign recov_clks_o = CNT_W'(tsel.recov_m2) + C_TWO;

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
   import ata_pio_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             is_write_i,
   input  logic [CNT_W-1:0] setup_clks_i,
   input  logic [CNT_W-1:0] pulse_clks_i,
   input  logic [CNT_W-1:0] recov_clks_i,
   output logic             busy_o,
   output logic             rd_act_o,
   output logic             wr_act_o
);

   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   pio_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pulse_q;
   logic [CNT_W-1:0] recov_q;
   logic             dir_q;
   logic             last;

   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         pulse_q <= '0;
         recov_q <= '0;
         dir_q   <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_SETUP;
                  cnt_q   <= setup_clks_i - C_ONE;
                  pulse_q <= pulse_clks_i;
                  recov_q <= recov_clks_i;
                  dir_q   <= is_write_i;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase_q <= PH_ACTIVE;
                  cnt_q   <= pulse_q - C_ONE;
               end else begin
                  cnt_q <= cnt_q - C_ONE;
               end
            end
            PH_ACTIVE: begin
               if (last) begin
                  phase_q <= PH_RECOV;
                  cnt_q   <= recov_q - C_ONE;
               end else begin
                  cnt_q <= cnt_q - C_ONE;
               end
            end
            PH_RECOV: begin
               if (last) begin
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - C_ONE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o   = (phase_q != PH_IDLE);
   assign rd_act_o = (phase_q == PH_ACTIVE) && !dir_q;
   assign wr_act_o = (phase_q == PH_ACTIVE) && dir_q;

endmodule

// File: rtl/ata_pio_timing_seq.sv
module ata_pio_timing_seq
   import ata_pio_pkg::*;
#(
   parameter int         ADDR_W         = 3,
   parameter int         NUM_SETS       = 2,
   parameter int         CNT_W          = 5,
   parameter bit         STB_ACTIVE_LOW = 1'b1,
   parameter int         OFS_RD_TIM     = 0,
   parameter int         OFS_WR_TIM     = 1,
   parameter int         OFS_KEY        = 2,
   parameter int         OFS_CTRL       = 3,
   parameter int         OFS_MISC       = 6,
   parameter logic [7:0] KEY_OPEN       = 8'h03,
   parameter logic [7:0] KEY_CLOSE      = 8'h83,
   parameter logic [7:0] CTRL_SPLIT     = 8'h85,
   parameter logic [7:0] CTRL_SET_B     = 8'hC0,
   localparam int        DRV_W          = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int        CFG_W          = 2 * NUM_SETS * 8 + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              cyc_req,
   input  logic              cyc_write,
   input  logic [DRV_W-1:0]  cyc_drive,
   output logic              dior_o,
   output logic              diow_o,
   output logic              busy_o
);

   // elaboration-time parameter checks
   if (CNT_W < 5) begin : g_err_cnt
      $error("CNT_W must hold the 17-clock recovery count");
   end
   if (NUM_SETS < 2 || NUM_SETS > 4) begin : g_err_sets
      $error("NUM_SETS must be 2 to 4 so set indices never carry setup bits");
   end
   if (OFS_KEY >= (1 << ADDR_W) || OFS_MISC >= (1 << ADDR_W) ||
       OFS_CTRL >= (1 << ADDR_W) || OFS_RD_TIM >= (1 << ADDR_W) ||
       OFS_WR_TIM >= (1 << ADDR_W)) begin : g_err_ofs
      $error("register offsets must fit in ADDR_W");
   end
   if (OFS_RD_TIM == OFS_WR_TIM || OFS_KEY == OFS_CTRL || OFS_KEY == OFS_MISC ||
       OFS_CTRL == OFS_MISC || OFS_KEY == OFS_RD_TIM || OFS_KEY == OFS_WR_TIM) begin : g_err_dup
      $error("register offsets must be distinct");
   end
   if (KEY_OPEN == KEY_CLOSE || CTRL_SPLIT == CTRL_SET_B) begin : g_err_key
      $error("key and control codes must be distinct");
   end

   cyc_timing_t [NUM_SETS-1:0] rd_sets;
   cyc_timing_t [NUM_SETS-1:0] wr_sets;
   logic [1:0]                 setup_m1;
   logic                       split;
   logic                       win_open;
   logic [CNT_W-1:0]           setup_clks;
   logic [CNT_W-1:0]           pulse_clks;
   logic [CNT_W-1:0]           recov_clks;
   logic                       start;
   logic                       rd_act;
   logic                       wr_act;
   logic                       busy;
   logic [CFG_W-1:0]           cfg_flat;

   ata_pio_regs #(
      .ADDR_W     (ADDR_W),
      .NUM_SETS   (NUM_SETS),
      .OFS_RD_TIM (OFS_RD_TIM),
      .OFS_WR_TIM (OFS_WR_TIM),
      .OFS_KEY    (OFS_KEY),
      .OFS_CTRL   (OFS_CTRL),
      .OFS_MISC   (OFS_MISC),
      .KEY_OPEN   (KEY_OPEN),
      .KEY_CLOSE  (KEY_CLOSE),
      .CTRL_SPLIT (CTRL_SPLIT),
      .CTRL_SET_B (CTRL_SET_B)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .rd_sets_o  (rd_sets),
      .wr_sets_o  (wr_sets),
      .setup_m1_o (setup_m1),
      .split_o    (split),
      .win_open_o (win_open)
   );

   ata_pio_sel #(
      .NUM_SETS (NUM_SETS),
      .CNT_W    (CNT_W)
   ) u_sel (
      .rd_sets_i    (rd_sets),
      .wr_sets_i    (wr_sets),
      .setup_m1_i   (setup_m1),
      .split_i      (split),
      .drive_i      (cyc_drive),
      .is_write_i   (cyc_write),
      .setup_clks_o (setup_clks),
      .pulse_clks_o (pulse_clks),
      .recov_clks_o (recov_clks)
   );

   assign start = cyc_req && !busy;

   ata_pio_fsm #(
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .is_write_i   (cyc_write),
      .setup_clks_i (setup_clks),
      .pulse_clks_i (pulse_clks),
      .recov_clks_i (recov_clks),
      .busy_o       (busy),
      .rd_act_o     (rd_act),
      .wr_act_o     (wr_act)
   );

   assign cfg_flat = {rd_sets, wr_sets, setup_m1, split};
   assign busy_o   = busy;

   if (STB_ACTIVE_LOW) begin : g_stb_low
      assign dior_o = ~rd_act;
      assign diow_o = ~wr_act;
   end else begin : g_stb_high
      assign dior_o = rd_act;
      assign diow_o = wr_act;
   end

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
   parameter int         ADDR_W   = 3,
   parameter int         CFG_W    = 35,
   parameter int         OFS_KEY  = 2,
   parameter logic [7:0] KEY_OPEN = 8'h03
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic [7:0]        host_wdata,
   input logic              cyc_req,
   input logic              busy,
   input logic              rd_act,
   input logic              wr_act,
   input logic              win_open,
   input logic [CFG_W-1:0]  cfg_flat
);

   localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);

   p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !busy && !rd_act && !wr_act);

   p_locked_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !win_open && host_addr != A_KEY) |=> $stable(cfg_flat));

   p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == A_KEY && host_wdata == KEY_OPEN) |=> win_open);

   p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_act, wr_act}));

   p_strobe_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act || wr_act) |-> busy);

   p_setup_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !(rd_act || wr_act));

   p_recovery_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_act || wr_act) |-> busy);

   p_start_by_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cyc_req));

endmodule

bind ata_pio_timing_seq ata_pio_seq_chk #(
   .ADDR_W   (ADDR_W),
   .CFG_W    (CFG_W),
   .OFS_KEY  (OFS_KEY),
   .KEY_OPEN (KEY_OPEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .cyc_req    (cyc_req),
   .busy       (busy),
   .rd_act     (rd_act),
   .wr_act     (wr_act),
   .win_open   (win_open),
   .cfg_flat   (cfg_flat)
);

// File: tb/tb_ata_pio_timing_seq.sv
`timescale 1ns/1ps
module tb_ata_pio_timing_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic [7:0] host_wdata = 8'd0;
   logic       cyc_req = 1'b0;
   logic       cyc_write = 1'b0;
   logic [0:0] cyc_drive = 1'b0;
   logic       dior_o;
   logic       diow_o;
   logic       busy_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ata_pio_timing_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .cyc_req    (cyc_req),
      .cyc_write  (cyc_write),
      .cyc_drive  (cyc_drive),
      .dior_o     (dior_o),
      .diow_o     (diow_o),
      .busy_o     (busy_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // behavioural reference: elapsed-clock count inside each cycle
   int m_open, m_ptr, m_setb, m_split, m_setup;
   int m_rd[2];
   int m_wr[2];
   int m_busy, m_k, m_total, m_s, m_p, m_dir;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_open = 0; m_ptr = 0; m_setb = 0; m_split = 0; m_setup = 4;
         m_rd[0] = 255; m_rd[1] = 255; m_wr[0] = 255; m_wr[1] = 255;
         m_busy = 0; m_k = 0; m_total = 0; m_s = 0; m_p = 0; m_dir = 0;
      end else begin
         if (m_busy != 0) begin
            if (m_k == m_total - 1) m_busy = 0;
            else m_k = m_k + 1;
         end else if (cyc_req) begin
            int bank, t;
            bank = (m_split != 0) ? int'(cyc_drive) : 0;
            t = cyc_write ? m_wr[bank] : m_rd[bank];
            m_s = m_setup;
            m_p = (t / 16) + 1;
            m_total = m_s + m_p + (t % 16) + 2;
            m_k = 0;
            m_dir = int'(cyc_write);
            m_busy = 1;
         end
         if (host_we) begin
            int d;
            d = int'(host_wdata);
            if (host_addr == 3'd2) begin
               if (d == 3) m_open = 1;
               else if (d == 131) m_open = 0;
            end else if (m_open != 0) begin
               case (int'(host_addr))
                  0: if (m_ptr == 0 || m_setb != 0) m_rd[m_ptr] = d;
                  1: if (m_ptr == 0 || m_setb != 0) m_wr[m_ptr] = d;
                  3: begin
                     if (d == 192) m_setb = 1;
                     else if (d == 133) m_split = 1;
                     else begin m_setb = 0; m_split = 0; end
                  end
                  6: begin
                     if (d < 2) m_ptr = d;
                     else m_setup = ((d / 16) % 4) + 1;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_rd, e_wr;
         e_rd = (m_busy != 0 && m_dir == 0 && m_k >= m_s && m_k < m_s + m_p) ? 1 : 0;
         e_wr = (m_busy != 0 && m_dir == 1 && m_k >= m_s && m_k < m_s + m_p) ? 1 : 0;
         chk(int'(busy_o) == m_busy, "R8", "lockstep busy", int'(busy_o), m_busy);
         chk(int'(!dior_o) == e_rd, "R8", "lockstep read strobe", int'(!dior_o), e_rd);
         chk(int'(!diow_o) == e_wr, "R8", "lockstep write strobe", int'(!diow_o), e_wr);
      end
   end

   task automatic hw(input int a, input int d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 3'(a); host_wdata = 8'(d);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic run_cycle(input bit wr, input int drv, input int es,
                            input int ep, input int er, input bit spam,
                            input string tag);
      int s, p, r, n, wrong;
      bit seen;
      s = 0; p = 0; r = 0; n = 0; wrong = 0; seen = 1'b0;
      @(negedge clk);
      cyc_req = 1'b1; cyc_write = wr; cyc_drive = 1'(drv);
      @(negedge clk);
      if (!spam) cyc_req = 1'b0;
      else begin cyc_write = !wr; cyc_drive = 1'(!drv[0]); end
      while (busy_o && n < 200) begin
         bit a, o;
         a = wr ? !diow_o : !dior_o;
         o = wr ? !dior_o : !diow_o;
         if (o) wrong = 1;
         if (a) begin p++; seen = 1'b1; end
         else if (!seen) s++;
         else r++;
         n++;
         @(negedge clk);
      end
      cyc_req = 1'b0;
      chk(s == es, tag, "setup clocks", s, es);
      chk(p == ep, tag, "active clocks", p, ep);
      chk(r == er, tag, "recovery clocks", r, er);
      chk(wrong == 0, tag, "other strobe active", wrong, 0);
      if (spam) begin
         @(negedge clk);
         chk(busy_o == 1'b0, tag, "busy after held request", int'(busy_o), 0);
      end
   endtask

   initial begin
      #(5ns * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
      chk(dior_o == 1'b1 && diow_o == 1'b1, "R1", "strobes idle in reset",
          int'({dior_o, diow_o}), 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
      run_cycle(1'b0, 0, 4, 16, 17, 1'b0, "R1");
      run_cycle(1'b1, 1, 4, 16, 17, 1'b0, "R1");

      // locked writes
      hw(0, 8'h00);
      hw(6, 8'h02);
      run_cycle(1'b0, 0, 4, 16, 17, 1'b0, "R2");

      // open, program set 0
      hw(2, 8'h03);
      hw(0, 8'h31);
      hw(6, 8'h12);
      run_cycle(1'b0, 0, 2, 4, 3, 1'b0, "R3");
      run_cycle(1'b1, 0, 2, 16, 17, 1'b0, "R4");
      hw(1, 8'h00);
      run_cycle(1'b1, 0, 2, 1, 2, 1'b0, "R4");
      run_cycle(1'b0, 0, 2, 4, 3, 1'b0, "R7");

      // set 1 access gating and drive mapping
      hw(6, 8'h01);
      hw(0, 8'h22);
      hw(3, 8'h85);
      run_cycle(1'b0, 1, 2, 16, 17, 1'b0, "R5");
      hw(3, 8'hC0);
      hw(0, 8'h22);
      run_cycle(1'b0, 1, 2, 3, 4, 1'b0, "R5");
      run_cycle(1'b0, 0, 2, 4, 3, 1'b0, "R6");
      hw(3, 8'h00);
      run_cycle(1'b0, 1, 2, 4, 3, 1'b0, "R6");

      // requests held while busy
      hw(3, 8'h85);
      run_cycle(1'b1, 0, 2, 1, 2, 1'b1, "R9");
      run_cycle(1'b0, 1, 2, 3, 4, 1'b1, "R9");

      // writes landing mid-cycle
      hw(6, 8'h00);
      fork
         run_cycle(1'b0, 0, 2, 4, 3, 1'b0, "R10");
         begin
            repeat (3) @(negedge clk);
            hw(6, 8'h30);
            hw(0, 8'hFF);
         end
      join
      run_cycle(1'b0, 0, 4, 16, 17, 1'b0, "R10");

      // close, then reopen
      hw(2, 8'h83);
      hw(0, 8'h10);
      run_cycle(1'b0, 0, 4, 16, 17, 1'b0, "R2");
      hw(2, 8'h55);
      hw(0, 8'h10);
      run_cycle(1'b0, 0, 4, 16, 17, 1'b0, "R2");
      hw(2, 8'h03);
      hw(0, 8'h10);
      run_cycle(1'b0, 0, 4, 2, 2, 1'b0, "R3");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule